// File: doc/BRIEF.md
# Compact 16-bit Multi-Cycle Processor Core

This block is a small multi-cycle processor that runs a sixteen-operation, 16-bit instruction set from a single synchronous memory port shared by code and data. Each instruction is read in one word, held in an instruction register, decoded and executed over two cycles. Loads and stores take a third cycle for the data access. Sixteen general registers, a zero flag, a sign flag, a program counter and one saved-return register make up all the architectural state. The zero and sign flags are also driven out as ports.

The memory port uses a request strobe, a write enable, an address, write data and read data. Read data is valid on the cycle after the request, and writes complete at the edge where the request is seen. The core is meant to sit beside a small local RAM and run control code with flat, single-level subroutine calls.

Top module: `tiny16_core`

## Requirements
- R1: While reset is held, the core requests a read (mem_req=1, mem_we=0) at address 0, all registers are zero, and both flags are 0.
- R2: Instruction word fields are opcode [15:12], destination [11:8], first source [7:4], second source [3:0]. An instruction that does not touch data memory takes two cycles: the fetch cycle at address PC, then one execute cycle with no request. The next fetch is at PC+1 unless the instruction changes the PC.
- R3: ADD (0001) and SUB (0010) write Rd with Ra+Rb or Ra−Rb, modulo 2^16.
- R4: MUL (0101) writes the low 16 bits of Ra×Rb. DIV (0110) writes the unsigned quotient Ra/Rb, or 16'hFFFF when Rb is zero.
- R5: AND (0111), OR (1000) and XOR (1001) write the bitwise result of Ra and Rb into Rd. NOT (1010) replaces Rd (bits [11:8]) with its bitwise inverse.
- R6: LOAD (0011) writes Rd with the memory word at the address held in Ra (bits [7:4]). It issues the read in the execute cycle and writes Rd one cycle later.
- R7: STORE (0100) writes register [11:8] to the address held in register [7:4]. The write strobe is high for exactly one cycle, in the cycle after execute.
- R8: CMP (0000) sets ZF when register [7:4] equals register [3:0], and sets SF when [7:4] is unsigned-less-than [3:0]. It writes no register, even when [11:8] is nonzero.
- R9: Only CMP changes ZF and SF. All other instructions leave both flags unchanged, including those whose result is zero.
- R10: JMP (1011) always loads PC with bits [11:0] zero-extended. JZ (1100) does so only when ZF=1, and JNZ (1101) only when ZF=0.
- R11: CALL (1110) saves the already-incremented PC into a single link register and jumps to [11:0]. RET (1111) loads PC from the link register, so a second CALL before a RET replaces the earlier return point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Store data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| flag_zero | output | 1 | Zero/equal flag from the last compare |
| flag_sign | output | 1 | Unsigned-less-than flag from the last compare |

## Verification
A single program builds its constants from the all-zero reset state and loads two operands from memory. It then stores every arithmetic and logic result, and each stored word is checked together with the flag values at that moment. Operand pairs are chosen to separate the cases: an addition that wraps to zero, a subtraction that borrows, a product that overflows 16 bits, and a zero divisor. Compares are run for greater, equal and less-than. Each is followed by taken and not-taken conditional jumps whose skipped stores would show up in the store sequence, and an XOR that gives zero checks that flags do not follow results. A plain call and return is checked against a nested call, and the nested call must keep returning into the inner routine.

// File: rtl/tiny16_pkg.sv
`timescale 1ns/1ps
package tiny16_pkg;

   typedef enum logic [3:0] {
      OP_CMP   = 4'b0000,
      OP_ADD   = 4'b0001,
      OP_SUB   = 4'b0010,
      OP_LOAD  = 4'b0011,
      OP_STORE = 4'b0100,
      OP_MUL   = 4'b0101,
      OP_DIV   = 4'b0110,
      OP_AND   = 4'b0111,
      OP_OR    = 4'b1000,
      OP_XOR   = 4'b1001,
      OP_NOT   = 4'b1010,
      OP_JMP   = 4'b1011,
      OP_JZ    = 4'b1100,
      OP_JNZ   = 4'b1101,
      OP_CALL  = 4'b1110,
      OP_RET   = 4'b1111
   } opcode_e;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_EXEC  = 2'd1,
      ST_MEM   = 2'd2
   } state_e;

   localparam int unsigned INSTR_W = 16;
   localparam int unsigned FIELD_W = 4;
   localparam int unsigned TARGET_W = 12;

   function automatic logic writes_reg(input opcode_e op);
      case (op)
         OP_ADD, OP_SUB, OP_MUL, OP_DIV,
         OP_AND, OP_OR, OP_XOR, OP_NOT: writes_reg = 1'b1;
         default:                       writes_reg = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tiny16_regfile.sv
`timescale 1ns/1ps
module tiny16_regfile #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NREGS  = 16,
   localparam int unsigned IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_val,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_val_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_val_b,
   input  logic [IDX_W-1:0]  rd_idx_d,
   output logic [DATA_W-1:0] rd_val_d
);

   logic [DATA_W-1:0] regs_q [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            regs_q[g] <= wr_val;
         end
      end
   end

   assign rd_val_a = regs_q[rd_idx_a];
   assign rd_val_b = regs_q[rd_idx_b];
   assign rd_val_d = regs_q[rd_idx_d];

endmodule

// File: rtl/tiny16_alu.sv
`timescale 1ns/1ps
module tiny16_alu
   import tiny16_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter bit          HAS_MUL = 1'b1,
   parameter bit          HAS_DIV = 1'b1
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result,
   output logic              is_eq,
   output logic              is_lt
);

   localparam int unsigned PROD_W = 2 * DATA_W;

   logic [DATA_W-1:0] mul_lo;
   logic [DATA_W-1:0] quot;

   if (HAS_MUL) begin : g_mul
      logic [PROD_W-1:0] prod;
      assign prod   = PROD_W'(opa) * PROD_W'(opb);
      assign mul_lo = prod[DATA_W-1:0];
   end else begin : g_no_mul
      assign mul_lo = '0;
   end

   if (HAS_DIV) begin : g_div
      assign quot = (opb == '0) ? '1 : (opa / opb);
   end else begin : g_no_div
      assign quot = '1;
   end

   always_comb begin
      case (op)
         OP_ADD:  result = opa + opb;
         OP_SUB:  result = opa - opb;
         OP_MUL:  result = mul_lo;
         OP_DIV:  result = quot;
         OP_AND:  result = opa & opb;
         OP_OR:   result = opa | opb;
         OP_XOR:  result = opa ^ opb;
         OP_NOT:  result = ~opa;
         default: result = '0;
      endcase
   end

   assign is_eq = (opa == opb);
   assign is_lt = (opa < opb);

endmodule

// File: rtl/tiny16_branch.sv
`timescale 1ns/1ps
module tiny16_branch
   import tiny16_pkg::*;
(
   input  opcode_e op,
   input  logic    zf,
   output logic    take_target,
   output logic    save_link,
   output logic    use_link
);

   always_comb begin
      take_target = 1'b0;
      save_link   = 1'b0;
      use_link    = 1'b0;
      case (op)
         OP_JMP:  take_target = 1'b1;
         OP_JZ:   take_target = zf;
         OP_JNZ:  take_target = !zf;
         OP_CALL: begin
            take_target = 1'b1;
            save_link   = 1'b1;
         end
         OP_RET:  use_link = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/tiny16_core.sv
`timescale 1ns/1ps
module tiny16_core
   import tiny16_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned NREGS   = 16,
   parameter bit          HAS_MUL = 1'b1,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              flag_zero,
   output logic              flag_sign
);

   localparam int unsigned IDX_W = $clog2(NREGS);
   localparam int unsigned TGT_W = (ADDR_W < TARGET_W) ? ADDR_W : TARGET_W;

   if (DATA_W != INSTR_W) begin : g_bad_width
      $error("tiny16_core: DATA_W must equal the instruction width");
   end
   if (NREGS < 2 || NREGS > (1 << FIELD_W) || (1 << IDX_W) != NREGS) begin : g_bad_regs
      $error("tiny16_core: NREGS must be a power of two between 2 and 16");
   end
   if (ADDR_W > DATA_W || ADDR_W < 2) begin : g_bad_addr
      $error("tiny16_core: ADDR_W must lie between 2 and DATA_W");
   end

   state_e              state_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [ADDR_W-1:0]   link_q;
   logic [INSTR_W-1:0]  ir_q;
   logic                zf_q;
   logic                sf_q;

   logic [INSTR_W-1:0]  instr;
   opcode_e             op;
   logic [IDX_W-1:0]    idx_d, idx_a, idx_b;
   logic [ADDR_W-1:0]   target;

   logic [DATA_W-1:0]   val_a, val_b, val_d;
   logic [DATA_W-1:0]   alu_opa, alu_y;
   logic                alu_eq, alu_lt;

   logic                rf_we;
   logic [DATA_W-1:0]   rf_wval;

   logic                br_take, br_save, br_ret;

   // In the execute cycle the fetched word arrives on the read bus; later cycles use the held copy.
   assign instr  = (state_q == ST_EXEC) ? mem_rdata : ir_q;
   assign op     = opcode_e'(instr[15:12]);
   assign idx_d  = instr[8 +: IDX_W];
   assign idx_a  = instr[4 +: IDX_W];
   assign idx_b  = instr[0 +: IDX_W];
   assign target = ADDR_W'(instr[TGT_W-1:0]);

   tiny16_regfile #(
      .DATA_W (DATA_W),
      .NREGS  (NREGS)
   ) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (rf_we),
      .wr_idx   (idx_d),
      .wr_val   (rf_wval),
      .rd_idx_a (idx_a),
      .rd_val_a (val_a),
      .rd_idx_b (idx_b),
      .rd_val_b (val_b),
      .rd_idx_d (idx_d),
      .rd_val_d (val_d)
   );

   assign alu_opa = (op == OP_NOT) ? val_d : val_a;

   tiny16_alu #(
      .DATA_W  (DATA_W),
      .HAS_MUL (HAS_MUL),
      .HAS_DIV (HAS_DIV)
   ) u_alu (
      .op     (op),
      .opa    (alu_opa),
      .opb    (val_b),
      .result (alu_y),
      .is_eq  (alu_eq),
      .is_lt  (alu_lt)
   );

   tiny16_branch u_br (
      .op          (op),
      .zf          (zf_q),
      .take_target (br_take),
      .save_link   (br_save),
      .use_link    (br_ret)
   );

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = pc_q;
      mem_wdata = val_d;
      rf_we     = 1'b0;
      rf_wval   = alu_y;
      case (state_q)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = pc_q;
         end
         ST_EXEC: begin
            rf_we = writes_reg(op);
            if (op == OP_LOAD) begin
               mem_req  = 1'b1;
               mem_addr = val_a[ADDR_W-1:0];
            end
         end
         ST_MEM: begin
            mem_addr = val_a[ADDR_W-1:0];
            if (op == OP_LOAD) begin
               rf_we   = 1'b1;
               rf_wval = mem_rdata;
            end else begin
               mem_req = 1'b1;
               mem_we  = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         link_q  <= '0;
         ir_q    <= '0;
         zf_q    <= 1'b0;
         sf_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_FETCH: begin
               pc_q    <= pc_q + ADDR_W'(1);
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               ir_q    <= mem_rdata;
               state_q <= ST_FETCH;
               if (op == OP_LOAD || op == OP_STORE) begin
                  state_q <= ST_MEM;
               end
               if (op == OP_CMP) begin
                  zf_q <= alu_eq;
                  sf_q <= alu_lt;
               end
               if (br_save) begin
                  link_q <= pc_q;
               end
               if (br_take) begin
                  pc_q <= target;
               end else if (br_ret) begin
                  pc_q <= link_q;
               end
            end
            ST_MEM: begin
               state_q <= ST_FETCH;
            end
            default: state_q <= ST_FETCH;
         endcase
      end
   end

   assign flag_zero = zf_q;
   assign flag_sign = sf_q;

endmodule

// File: rtl/tiny16_core_chk.sv
`timescale 1ns/1ps
module tiny16_core_chk
   import tiny16_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input state_e            state,
   input opcode_e           op,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] link,
   input logic              zf,
   input logic              sf,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic              rf_we,
   input logic              mem_req,
   input logic              mem_we
);

   p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH) |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))) && (state == ST_EXEC));

   p_cmp_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_CMP) |=>
         (zf == ($past(src_a) == $past(src_b))) && (sf == ($past(src_a) < $past(src_b))));

   p_cmp_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_CMP) |-> !rf_we);

   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(state == ST_EXEC && op == OP_CMP) |=> ($stable(zf) && $stable(sf)));

   p_load_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_LOAD) |-> (mem_req && !mem_we));

   p_load_then_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_LOAD) |=> (state == ST_MEM));

   p_store_in_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_req && state == ST_MEM));

   p_store_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   p_call_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_CALL) |=> (link == $past(pc)));

   p_ret_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && op == OP_RET) |=> (pc == $past(link)));

endmodule

bind tiny16_core tiny16_core_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .state   (state_q),
   .op      (op),
   .pc      (pc_q),
   .link    (link_q),
   .zf      (zf_q),
   .sf      (sf_q),
   .src_a   (val_a),
   .src_b   (val_b),
   .rf_we   (rf_we),
   .mem_req (mem_req),
   .mem_we  (mem_we)
);

// File: tb/tb_tiny16_core.sv
`timescale 1ns/1ps
module tb_tiny16_core;

   localparam int DW = 16;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          flag_zero, flag_sign;

   always #5 clk = ~clk;

   tiny16_core dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .flag_zero (flag_zero),
      .flag_sign (flag_sign)
   );

   logic [DW-1:0] ram [512];

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) ram[mem_addr[8:0]] <= mem_wdata;
         mem_rdata <= ram[mem_addr[8:0]];
      end
   end

   typedef struct {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      logic          zf;
      logic          sf;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   int   p = 0;
   logic [AW-1:0] res_ptr = 12'h100;

   function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] d,
                                       input logic [3:0] a, input logic [3:0] b);
      return {op, d, a, b};
   endfunction

   function automatic logic [15:0] encj(input logic [3:0] op, input int t);
      return {op, 12'(t)};
   endfunction

   task automatic emit(input logic [15:0] w);
      ram[p] = w;
      p++;
   endtask

   // Store register r at the result pointer (R5), then advance it by R2 (=1).
   task automatic emit_store(input logic [3:0] r);
      emit(enc(4'b0100, r, 4'd5, 4'd0));
      emit(enc(4'b0001, 4'd5, 4'd5, 4'd2));
   endtask

   task automatic expect_store(input logic [DW-1:0] d, input logic zf, input logic sf,
                               input string req);
      exp_t e;
      e.addr = res_ptr; e.data = d; e.zf = zf; e.sf = sf; e.req = req;
      exp_q.push_back(e);
      res_ptr = res_ptr + 12'd1;
   endtask

   task automatic st(input logic [3:0] r, input logic [DW-1:0] d, input logic zf,
                     input logic sf, input string req);
      emit_store(r);
      expect_store(d, zf, sf, req);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // Scoreboard monitor: every write on the memory port is compared with the next expected item.
   always @(negedge clk) begin
      if (rst_n && mem_req && mem_we && !done) begin
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(mem_addr == e.addr && mem_wdata == e.data &&
                  flag_zero == e.zf && flag_sign == e.sf, e.req, "store addr/data/zf/sf",
                  {mem_addr, mem_wdata, 2'b00, flag_zero, flag_sign},
                  {e.addr, e.data, 2'b00, e.zf, e.sf});
            if (exp_q.size() == 0) done = 1'b1;
         end
      end
   end

   task automatic build_program();
      int s1, q;
      for (int i = 0; i < 512; i++) ram[i] = '0;
      ram[9'h080] = 16'h1234;
      ram[9'h081] = 16'h00FF;
      p = 0;
      emit(enc(4'b0001, 4'd0, 4'd0, 4'd0));            // ADD R0 (timing probe)
      emit(enc(4'b1010, 4'd1, 4'd0, 4'd0));            // NOT R1 -> FFFF
      emit(enc(4'b0010, 4'd2, 4'd0, 4'd1));            // SUB R2 = 0-FFFF = 1
      emit(enc(4'b0001, 4'd3, 4'd2, 4'd2));            // R3 = 2
      for (int i = 0; i < 6; i++) emit(enc(4'b0001, 4'd3, 4'd3, 4'd3)); // R3 = 0x80
      emit(enc(4'b0001, 4'd4, 4'd3, 4'd2));            // R4 = 0x81
      emit(enc(4'b0001, 4'd5, 4'd3, 4'd3));            // R5 = 0x100
      emit(enc(4'b0011, 4'd6, 4'd3, 4'd0));            // LOAD R6 = 0x1234
      emit(enc(4'b0011, 4'd7, 4'd4, 4'd0));            // LOAD R7 = 0x00FF
      st(4'd6, 16'h1234, 1'b0, 1'b0, "R6");
      emit(enc(4'b0001, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'h1333, 1'b0, 1'b0, "R3");
      emit(enc(4'b0001, 4'd8, 4'd1, 4'd2)); st(4'd8, 16'h0000, 1'b0, 1'b0, "R3");
      emit(enc(4'b0010, 4'd8, 4'd7, 4'd6)); st(4'd8, 16'hEECB, 1'b0, 1'b0, "R3");
      emit(enc(4'b0101, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'h21CC, 1'b0, 1'b0, "R4");
      emit(enc(4'b0110, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'h0012, 1'b0, 1'b0, "R4");
      emit(enc(4'b0110, 4'd8, 4'd6, 4'd0)); st(4'd8, 16'hFFFF, 1'b0, 1'b0, "R4");
      emit(enc(4'b0111, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'h0034, 1'b0, 1'b0, "R5");
      emit(enc(4'b1000, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'h12FF, 1'b0, 1'b0, "R5");
      emit(enc(4'b1001, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'h12CB, 1'b0, 1'b0, "R5");
      emit(enc(4'b1010, 4'd8, 4'd0, 4'd0)); st(4'd8, 16'hED34, 1'b0, 1'b0, "R5");
      // CMP greater: dest field names R8, which must stay untouched
      emit(enc(4'b0000, 4'd8, 4'd6, 4'd7)); st(4'd8, 16'hED34, 1'b0, 1'b0, "R8");
      emit(encj(4'b1100, p + 3)); st(4'd2, 16'h0001, 1'b0, 1'b0, "R10");   // JZ not taken
      emit(encj(4'b1101, p + 3)); emit_store(4'd1);                        // JNZ taken (R10)
      // CMP equal
      emit(enc(4'b0000, 4'd0, 4'd6, 4'd6));
      emit(encj(4'b1100, p + 3)); emit_store(4'd1);                        // JZ taken (R10)
      emit(encj(4'b1101, p + 3)); st(4'd2, 16'h0001, 1'b1, 1'b0, "R10");   // JNZ not taken
      emit(enc(4'b0001, 4'd9, 4'd6, 4'd7)); st(4'd9, 16'h1333, 1'b1, 1'b0, "R9");
      // CMP less-than
      emit(enc(4'b0000, 4'd0, 4'd7, 4'd6)); st(4'd7, 16'h00FF, 1'b0, 1'b1, "R8");
      emit(enc(4'b1001, 4'd9, 4'd6, 4'd6)); st(4'd9, 16'h0000, 1'b0, 1'b1, "R9");
      emit(encj(4'b1011, p + 3)); emit_store(4'd1);                        // JMP skips (R10)
      // Subroutine s1 stores R6
      emit(encj(4'b1011, p + 4));
      s1 = p;
      emit_store(4'd6);
      emit(16'hF000);                                                      // RET
      emit(encj(4'b1110, s1)); expect_store(16'h1234, 1'b0, 1'b1, "R11");
      st(4'd1, 16'hFFFF, 1'b0, 1'b1, "R11");
      // Nested: routine q calls s1, then stores R7 and returns to its own body forever
      emit(encj(4'b1011, p + 5));
      q = p;
      emit(encj(4'b1110, s1));
      emit_store(4'd7);
      emit(16'hF000);
      emit(encj(4'b1110, q));
      expect_store(16'h1234, 1'b0, 1'b1, "R11");
      for (int i = 0; i < 3; i++) expect_store(16'h00FF, 1'b0, 1'b1, "R11");
   endtask

   initial begin
      int cyc;
      build_program();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(mem_req == 1'b1 && mem_we == 1'b0 && mem_addr == '0, "R1", "reset request",
            {mem_req, mem_we, mem_addr}, 32'h2000);
      check(flag_zero == 1'b0 && flag_sign == 1'b0, "R1", "reset flags",
            {flag_zero, flag_sign}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(mem_req == 1'b0, "R2", "no request in execute", mem_req, 32'h0);
      @(negedge clk);
      check(mem_req == 1'b1 && mem_we == 1'b0 && mem_addr == 12'd1, "R2", "second fetch",
            {mem_req, mem_we, mem_addr}, 32'h2001);
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: %0d stores still pending", exp_q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule